// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block closes an I2C transfer on the master side by producing a Stop condition on the bus. The byte engine holds SCL low after the acknowledge clock of the last byte. It then pulses a stop request. The sequencer takes over both lines and walks three timed steps, each as long as one baud-rate period. First, SDA and SCL are both held low. Next, SCL is released and the block waits out its high time. Last, SDA is released.

Both lines are open-drain, so the block only drives enables that pull a line low. It reads back the sampled line levels. This lets it wait out clock stretching on SCL, and it raises its stop flag only when SDA is really seen high. A busy bit shows the sequence in progress and clears itself when the sequence ends. At that moment an interrupt-request pulse is issued.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, both drive enables, the busy bit, the stop flag and the interrupt pulse are all 0.
- R2: A stop request is accepted only while the block is idle and SCL reads low (the acknowledge clock has ended); a request while SCL reads high leaves busy at 0 and both enables at 0.
- R3: In the cycle after an accepted request, busy, the SCL enable and the SDA enable are all 1, so SDA is low before SCL can rise.
- R4: The SCL enable stays 1 for exactly N cycles after acceptance, where N is the reload value (a reload of 0 counts as 1). The SDA enable stays 1 throughout.
- R5: After SCL is released, the SDA enable stays 1 for N cycles in which SCL reads high. Cycles in which SCL is held low by another device are not counted.
- R6: The stop flag is set only once SDA reads high after its release. While SDA is held low externally, the block waits with busy at 1 and the flag at 0.
- R7: N cycles after SDA is sampled high, busy clears and the interrupt output is 1 for exactly one cycle, in the same cycle busy drops. Without stretching, busy lasts 3N+1 cycles.
- R8: A stop request that arrives while busy is ignored and does not change the length of the sequence.
- R9: Reset asserted in the middle of a sequence releases both lines and clears busy at once.
- R10: The stop flag stays set after completion and is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Stop request pulse from the byte engine |
| brgReload | input | BRG_W | Baud-rate period in clock cycles |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Self-clearing stop-in-progress bit |
| stopDet | output | 1 | Stop seen on the bus (SDA read high) |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that sclIn and sdaIn are already synchronized line levels. They also assume that a released line reads back high in the same cycle unless another device pulls it low, which is how a wired-AND bus behaves. The bench meets this by building each line as the continuous AND of the block's release and its own device model. It changes its inputs only on the falling clock edge. It holds SCL low itself before every request, so that acceptance follows the rules.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LOW,
    ST_SCL_HIGH,
    ST_SDA_REL,
    ST_FINISH
  } stopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // reload period counter
    logic count;    // decrement period counter
    logic setDet;   // set stop flag
    logic clrDet;   // clear stop flag
    logic fireIrq;  // issue completion pulse
  } dpStrobe_t;

endpackage

// File: rtl/i2c_stop_dp.sv
module i2c_stop_dp
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BRG_W-1:0] brgReload,
  output logic             cntDone,
  output logic             stopDet,
  output logic             irq
);

  localparam logic [BRG_W-1:0] ONE = BRG_W'(1);

  logic [BRG_W-1:0] periodCnt;

  // last counting cycle of a step; a zero reload behaves as one
  assign cntDone = (periodCnt <= ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (strobe.load) begin
      periodCnt <= brgReload;
    end else if (strobe.count && (periodCnt != '0)) begin
      periodCnt <= periodCnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopDet <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (strobe.clrDet)      stopDet <= 1'b0;
      else if (strobe.setDet) stopDet <= 1'b1;
      irq <= strobe.fireIrq;
    end
  end

endmodule

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl
  import i2c_stop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      cntDone,
  output dpStrobe_t strobe,
  output logic      sclOe,
  output logic      sdaOe,
  output logic      busy
);

  stopState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (stopReq && !sclIn) begin
          strobe.load   = 1'b1;
          strobe.clrDet = 1'b1;
          stateNext     = ST_SDA_LOW;
        end
      end
      ST_SDA_LOW: begin
        strobe.count = 1'b1;
        if (cntDone) begin
          strobe.load = 1'b1;
          stateNext   = ST_SCL_HIGH;
        end
      end
      ST_SCL_HIGH: begin
        // stretched SCL freezes the period count
        if (sclIn) begin
          strobe.count = 1'b1;
          if (cntDone) stateNext = ST_SDA_REL;
        end
      end
      ST_SDA_REL: begin
        if (sdaIn) begin
          strobe.setDet = 1'b1;
          strobe.load   = 1'b1;
          stateNext     = ST_FINISH;
        end
      end
      ST_FINISH: begin
        strobe.count = 1'b1;
        if (cntDone) begin
          strobe.fireIrq = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign sclOe = (state == ST_SDA_LOW);
  assign sdaOe = (state == ST_SDA_LOW) || (state == ST_SCL_HIGH);
  assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
  import i2c_stop_pkg::*;
#(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic [BRG_W-1:0] brgReload,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             stopDet,
  output logic             irq
);

  dpStrobe_t strobe;
  logic      cntDone;

  i2c_stop_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stopReq (stopReq),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .cntDone (cntDone),
    .strobe  (strobe),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe),
    .busy    (busy)
  );

  i2c_stop_dp #(.BRG_W(BRG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .brgReload (brgReload),
    .cntDone   (cntDone),
    .stopDet   (stopDet),
    .irq       (irq)
  );

endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk (
  input logic clk,
  input logic rstN,
  input logic stopReq,
  input logic sclIn,
  input logic sdaIn,
  input logic sclOe,
  input logic sdaOe,
  input logic busy,
  input logic stopDet,
  input logic irq
);

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopReq && !sclIn) |=> (busy && sclOe && sdaOe)); // R3

  AST_IGNORE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopReq && sclIn) |=> !busy); // R2

  AST_SCL_UNDER_SDA: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> sdaOe); // R4

  AST_SDA_AFTER_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclOe); // R5

  AST_FLAG_NEEDS_SDA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopDet) |-> $past(sdaIn)); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R7

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && $past(busy))); // R7

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe || sdaOe) |-> busy); // R9

endmodule

bind i2c_stop_gen i2c_stop_chk u_chk (.*);

// File: tb/test_i2c_stop_gen.sv
module test_i2c_stop_gen;

  localparam int BRG_W = 8;
  localparam int VEC_N = 6;
  // reload value and SCL stretch cycles per vector
  localparam int vecReload [VEC_N] = '{1, 2, 3, 5, 4, 0};
  localparam int vecStretch[VEC_N] = '{0, 0, 2, 0, 3, 0};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             stopReq = 1'b0;
  logic [BRG_W-1:0] brgReload = '0;
  logic             tbSclLow = 1'b0;
  logic             tbSdaLow = 1'b0;
  logic             sclIn, sdaIn, sclOe, sdaOe, busy, stopDet, irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  // wired-AND bus
  assign sclIn = !(sclOe || tbSclLow);
  assign sdaIn = !(sdaOe || tbSdaLow);

  i2c_stop_gen #(.BRG_W(BRG_W)) i_i2c_stop_gen (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .brgReload(brgReload),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe),
    .busy(busy), .stopDet(stopDet), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full stop sequence, measured at falling edges
  task automatic runSeq(int reload, int stretch, int reReqAt);
    int nEff = (reload == 0) ? 1 : reload;
    int busyCnt = 0, sclCnt = 0, sdaCnt = 0, irqCnt = 0;
    int stretchLeft = stretch;
    @(negedge clk);
    brgReload = BRG_W'(reload);
    tbSclLow  = 1'b1;
    stopReq   = 1'b1;
    for (int i = 0; i < 3 * nEff + stretch + 12; i++) begin
      @(negedge clk);
      if (i == 0) begin
        stopReq = 1'b0;
        check("R3 busy after accept", int'(busy), 1);
        check("R3 SCL and SDA held", int'(sclOe && sdaOe), 1);
      end
      if (i == reReqAt) stopReq = 1'b1;
      if (i == reReqAt + 1) stopReq = 1'b0;
      if (busy)  busyCnt++;
      if (sclOe) sclCnt++;
      if (sdaOe) sdaCnt++;
      if (irq)   irqCnt++;
      if (busy && sdaOe && !sclOe && stretchLeft > 0) begin
        tbSclLow = 1'b1;
        stretchLeft--;
      end else begin
        tbSclLow = 1'b0;
      end
    end
    check("R4 SCL low cycles", sclCnt, nEff);
    check("R5 SDA low cycles", sdaCnt, 2 * nEff + stretch);
    check(reReqAt >= 0 ? "R8 busy cycles" : "R7 busy cycles", busyCnt, 3 * nEff + 1 + stretch);
    check("R7 irq pulses", irqCnt, 1);
    check("R6 stop flag", int'(stopDet), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sclOe", int'(sclOe), 0);
    check("R1 sdaOe", int'(sdaOe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 stopDet", int'(stopDet), 0);
    check("R1 irq", int'(irq), 0);
    rstN = 1'b1;

    // R2 request with SCL high is ignored
    @(negedge clk);
    brgReload = 8'd2;
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R2 busy", int'(busy), 0);
    check("R2 drives", int'(sclOe || sdaOe), 0);

    for (int v = 0; v < VEC_N; v++) runSeq(vecReload[v], vecStretch[v], -1);

    // R8 second request while busy
    runSeq(3, 0, 2);

    // R6 SDA held low externally, then R10 flag cleared by next accept
    tbSdaLow = 1'b1;
    @(negedge clk);
    brgReload = 8'd2;
    tbSclLow = 1'b1;
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    tbSclLow = 1'b0;
    check("R10 flag cleared on accept", int'(stopDet), 0);
    repeat (20) @(negedge clk);
    check("R6 waiting busy", int'(busy), 1);
    check("R6 flag stays clear", int'(stopDet), 0);
    check("R6 SDA released", int'(sdaOe), 0);
    tbSdaLow = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 flag after SDA high", int'(stopDet), 1);
    repeat (10) @(negedge clk);
    check("R7 done after SDA high", int'(busy), 0);
    check("R10 flag held after done", int'(stopDet), 1);

    // R9 reset mid-sequence
    @(negedge clk);
    brgReload = 8'd4;
    tbSclLow = 1'b1;
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    tbSclLow = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9 busy cleared", int'(busy), 0);
    check("R9 lines released", int'(sclOe || sdaOe), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stays idle", int'(busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule